// File: doc/BRIEF.md
# NAND command and address sequencer

This block is the device-side front end of a NAND flash interface. On every write strobe it samples an 8-bit I/O bus and sorts the byte by the latch-enable lines. With chip enable low and the command latch high, the byte is a command. With the address latch high, the byte is an address byte. Address bytes are assembled least-significant first into a 40-bit address register. The block keeps the current command code and a column offset. It raises single-cycle trigger pulses for the operations that the storage array behind it carries out.

The array, data read-out and data latching are outside the block. Parameters select the page format: small page or large page. They also select an 8- or 16-bit bus and the device capacity. Between them, these set the address cycle at which a read or program starts and the shift that turns an erase address into a row address.

Top module: `nand_cmd_addr_seq`

## Requirements
- R1: A byte is taken as a command only on a strobe (`wr_stb` high) with `ce_n` low and `cle` high. It is taken as an address byte on any strobe with `ale` high, whatever `ce_n` is. A strobe with neither, or no strobe at all, changes no output.
- R2: Each address byte replaces byte lane N (bits 8N+7..8N) of the address, where N is the number of address bytes taken since the last command. N then increments. Lanes above the fifth are dropped. Any accepted command clears N, except 0xE0, which keeps it.
- R3: Command 0x00 sets the column offset to 0. Command 0x01 sets it to 0x100 and becomes command 0x00. Command 0x50 sets it to the page size (2048 for large page, `SMALL_PAGE_BYTES` otherwise) and becomes command 0x00.
- R4: In large-page mode, 0x30 arriving while the command is 0x00 is dropped entirely. Also in large-page mode, 0x05 clears address bits 15..0 and N, and leaves the command unchanged. In small-page mode both latch as ordinary codes.
- R5: The following pulses fire on the edge that latches their command: 0x70 → `t_status`, 0x10 → `t_prog_go`, 0xD0 → `t_erase`, 0xFF → `t_reset`. The codes 0x35 and 0xE0 fire `t_rd_col`, but only in large-page mode.
- R6: With command 0x90, the first address byte fires `t_id`.
- R7: With command 0x00, address byte number E fires `t_rd_load`; with command 0x80 it fires `t_prog_setup`. E is 3 for small page, 4 for large page up to 1024 Mbit, and 5 above that.
- R8: With `BUS16` set, the whole address shifts left by one bit when the second address byte is taken.
- R9: On 0xD0 the address keeps only the N lanes received. It is then shifted left by 16 bits (large page) or 8 bits (small page).
- R10: Command 0xFF sets the command to 0x00 and clears the address, N and the column offset.
- R11: Trigger outputs are one cycle wide and at most one is high at a time. A cycle without a strobe is followed by no trigger. Unknown codes latch into `cmd_q` and fire nothing.
- R12: Synchronous reset `rst` gives command 0x00, a zero address, a zero offset and no triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one byte per cycle it is high |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io_in | input | 8 | I/O bus byte |
| cmd_q | output | 8 | Current command code |
| addr_q | output | 40 | Assembled address |
| col_ofs | output | 16 | Column offset |
| t_rd_load | output | 1 | Page read start pulse |
| t_rd_col | output | 1 | Column-change read pulse |
| t_prog_setup | output | 1 | Program address complete pulse |
| t_prog_go | output | 1 | Program confirm pulse |
| t_erase | output | 1 | Block erase pulse |
| t_status | output | 1 | Status read pulse |
| t_id | output | 1 | Identification read pulse |
| t_reset | output | 1 | Device reset pulse |

## Verification
The hardest state to reach is an address count that does not start from zero. A 0x05 column set clears the count in the middle of an address. A 0xE0 then carries the count over, so the next address byte lands in lane 2 rather than lane 0. The stimulus walks one long vector table through a full five-cycle read. It follows with a column set, two bytes, 0xE0 and a third byte, and checks the lane that byte lands in. A second instance in small-page, 16-bit form receives the same stream. It shows the three-cycle start, the bus shift and the 8-bit row shift on erase, against the large-page instance that must stay silent.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READ_HALF = 8'h01;
  localparam logic [7:0] OP_READ_OOB  = 8'h50;
  localparam logic [7:0] OP_LP_CONF   = 8'h30;
  localparam logic [7:0] OP_CACHE_RD  = 8'h35;
  localparam logic [7:0] OP_COL_SET   = 8'h05;
  localparam logic [7:0] OP_COL_GO    = 8'hE0;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PROG      = 8'h80;
  localparam logic [7:0] OP_PROG_GO   = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h60;
  localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;

  typedef struct packed {
    logic rd_load;
    logic rd_col;
    logic prog_setup;
    logic prog_go;
    logic erase;
    logic status;
    logic id;
    logic rst;
  } trig_t;
endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_seq_pkg::*;
#(
  parameter bit LARGE      = 1'b1,
  parameter int OFS_W      = 16,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [7:0]       byte_in,
  input  logic [7:0]       cur_cmd,
  output logic             drop,
  output logic             col_clr,
  output logic [7:0]       new_cmd,
  output logic             ofs_we,
  output logic [OFS_W-1:0] ofs_val,
  output logic             cnt_keep,
  output logic             soft_rst,
  output logic             erase_fix,
  output trig_t            imm
);
  always_comb begin
    drop      = 1'b0;
    col_clr   = 1'b0;
    new_cmd   = byte_in;
    ofs_we    = 1'b0;
    ofs_val   = '0;
    cnt_keep  = 1'b0;
    soft_rst  = 1'b0;
    erase_fix = 1'b0;
    imm       = '0;
    if (LARGE && cur_cmd == OP_READ && byte_in == OP_LP_CONF) begin
      drop = 1'b1;
    end else if (LARGE && byte_in == OP_COL_SET) begin
      col_clr = 1'b1;
    end else begin
      case (byte_in)
        OP_READ: ofs_we = 1'b1;
        OP_READ_HALF: begin
          ofs_we  = 1'b1;
          ofs_val = OFS_W'(256);
          new_cmd = OP_READ;
        end
        OP_READ_OOB: begin
          ofs_we  = 1'b1;
          ofs_val = OFS_W'(PAGE_BYTES);
          new_cmd = OP_READ;
        end
        OP_STATUS:   imm.status  = 1'b1;
        OP_PROG_GO:  imm.prog_go = 1'b1;
        OP_ERASE_GO: begin
          imm.erase = 1'b1;
          erase_fix = 1'b1;
        end
        OP_CACHE_RD: imm.rd_col = LARGE;
        OP_COL_GO: begin
          imm.rd_col = LARGE;
          cnt_keep   = 1'b1;
        end
        OP_RESET: begin
          soft_rst = 1'b1;
          imm.rst  = 1'b1;
          new_cmd  = OP_READ;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_addr_accum.sv
module nand_addr_accum #(
  parameter int ADDR_BYTES = 5,
  parameter bit LARGE      = 1'b1,
  parameter bit BUS16      = 1'b0,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    col_clr,
  input  logic                    soft_rst,
  input  logic                    cmd_hit,
  input  logic                    erase_fix,
  input  logic                    cnt_keep,
  input  logic                    addr_hit,
  input  logic [7:0]              byte_in,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic [CNT_W-1:0]        cnt_after
);
  localparam int ADDR_W    = 8 * ADDR_BYTES;
  localparam int ROW_SHIFT = LARGE ? 16 : 8;
  localparam int COL_BITS  = 16;

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] a_nx;
  logic [ADDR_W-1:0] kept;
  logic [CNT_W-1:0]  c_nx;

  always_comb begin
    a_nx = addr_q;
    c_nx = cnt_q;
    kept = '0;
    if (col_clr) begin
      a_nx[COL_BITS-1:0] = '0;
      c_nx = '0;
    end else if (soft_rst) begin
      a_nx = '0;
      c_nx = '0;
    end else if (cmd_hit) begin
      if (erase_fix) begin
        for (int i = 0; i < ADDR_BYTES; i++)
          if (CNT_W'(i) < cnt_q) kept[8*i +: 8] = addr_q[8*i +: 8];
        a_nx = kept << ROW_SHIFT;
      end
      if (!cnt_keep) c_nx = '0;
    end
    if (addr_hit) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (c_nx == CNT_W'(i)) a_nx[8*i +: 8] = byte_in;
      if (c_nx != '1) c_nx = c_nx + CNT_W'(1);
      if (BUS16 && c_nx == CNT_W'(2)) a_nx = a_nx << 1;
    end
  end

  assign cnt_after = c_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= a_nx;
      cnt_q  <= c_nx;
    end
  end

  p_col_clear_r4: assert property (@(posedge clk) disable iff (rst)
    col_clr |=> (addr_q[COL_BITS-1:0] == '0));
endmodule

// File: rtl/nand_exec_point.sv
module nand_exec_point
  import nand_seq_pkg::*;
#(
  parameter bit LARGE   = 1'b1,
  parameter bit BIG_CAP = 1'b1,
  parameter int CNT_W   = 3
) (
  input  logic             addr_hit,
  input  logic [7:0]       cmd_now,
  input  logic [CNT_W-1:0] cnt_after,
  output logic             rd_load,
  output logic             prog_setup,
  output logic             id
);
  localparam int EXEC_CYC = LARGE ? (BIG_CAP ? 5 : 4) : 3;

  always_comb begin
    rd_load    = addr_hit && cmd_now == OP_READ  && cnt_after == CNT_W'(EXEC_CYC);
    prog_setup = addr_hit && cmd_now == OP_PROG  && cnt_after == CNT_W'(EXEC_CYC);
    id         = addr_hit && cmd_now == OP_IDENT && cnt_after == CNT_W'(1);
  end
endmodule

// File: rtl/nand_cmd_addr_seq.sv
module nand_cmd_addr_seq
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE       = 1'b1,
  parameter bit BUS16            = 1'b0,
  parameter int CAP_MBIT         = 2048,
  parameter int SMALL_PAGE_BYTES = 512,
  parameter int ADDR_BYTES       = 5,
  parameter int OFS_W            = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_stb,
  input  logic                    ce_n,
  input  logic                    cle,
  input  logic                    ale,
  input  logic [7:0]              io_in,
  output logic [7:0]              cmd_q,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic [OFS_W-1:0]        col_ofs,
  output logic                    t_rd_load,
  output logic                    t_rd_col,
  output logic                    t_prog_setup,
  output logic                    t_prog_go,
  output logic                    t_erase,
  output logic                    t_status,
  output logic                    t_id,
  output logic                    t_reset
);
  localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : SMALL_PAGE_BYTES;
  localparam bit BIG_CAP    = (CAP_MBIT > 1024);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 3);

  logic             cle_hit, cmd_hit, addr_hit;
  logic             drop, col_clr, ofs_we, cnt_keep, soft_rst, erase_fix;
  logic [7:0]       new_cmd, cmd_now;
  logic [OFS_W-1:0] ofs_val;
  logic [CNT_W-1:0] cnt_after;
  logic             x_rd, x_prog, x_id;
  trig_t            imm, trig_nx, trig_q;

  assign cle_hit  = wr_stb && !ce_n && cle;
  assign cmd_hit  = cle_hit && !drop && !col_clr;
  assign addr_hit = wr_stb && ale && !(cle_hit && (drop || col_clr));
  assign cmd_now  = cmd_hit ? new_cmd : cmd_q;

  nand_cmd_decode #(.LARGE(LARGE_PAGE), .OFS_W(OFS_W), .PAGE_BYTES(PAGE_BYTES)) u_dec (
    .byte_in(io_in), .cur_cmd(cmd_q), .drop(drop), .col_clr(col_clr),
    .new_cmd(new_cmd), .ofs_we(ofs_we), .ofs_val(ofs_val), .cnt_keep(cnt_keep),
    .soft_rst(soft_rst), .erase_fix(erase_fix), .imm(imm)
  );

  nand_addr_accum #(.ADDR_BYTES(ADDR_BYTES), .LARGE(LARGE_PAGE), .BUS16(BUS16),
                    .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .col_clr(cle_hit && col_clr),
    .soft_rst(cmd_hit && soft_rst), .cmd_hit(cmd_hit),
    .erase_fix(cmd_hit && erase_fix), .cnt_keep(cnt_keep),
    .addr_hit(addr_hit), .byte_in(io_in), .addr_q(addr_q), .cnt_after(cnt_after)
  );

  nand_exec_point #(.LARGE(LARGE_PAGE), .BIG_CAP(BIG_CAP), .CNT_W(CNT_W)) u_exec (
    .addr_hit(addr_hit), .cmd_now(cmd_now), .cnt_after(cnt_after),
    .rd_load(x_rd), .prog_setup(x_prog), .id(x_id)
  );

  always_comb begin
    trig_nx            = cmd_hit ? imm : '0;
    trig_nx.rd_load    = x_rd;
    trig_nx.prog_setup = x_prog;
    trig_nx.id         = x_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= OP_READ;
      col_ofs <= '0;
      trig_q  <= '0;
    end else begin
      trig_q <= trig_nx;
      if (cmd_hit) cmd_q <= new_cmd;
      if (cmd_hit && ofs_we) col_ofs <= ofs_val;
      else if (cmd_hit && soft_rst) col_ofs <= '0;
    end
  end

  assign t_rd_load    = trig_q.rd_load;
  assign t_rd_col     = trig_q.rd_col;
  assign t_prog_setup = trig_q.prog_setup;
  assign t_prog_go    = trig_q.prog_go;
  assign t_erase      = trig_q.erase;
  assign t_status     = trig_q.status;
  assign t_id         = trig_q.id;
  assign t_reset      = trig_q.rst;

  p_quiet_no_trig_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> (trig_q == '0));
  p_trig_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_q));
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(cmd_q) && $stable(col_ofs) && $stable(addr_q)));
  p_soft_rst_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ce_n && cle && io_in == OP_RESET)
      |=> (cmd_q == OP_READ && addr_q == '0 && col_ofs == '0));
  p_half_ofs_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ce_n && cle && io_in == OP_READ_HALF)
      |=> (col_ofs == OFS_W'(256) && cmd_q == OP_READ));
  p_id_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    t_id |-> (cmd_q == OP_IDENT));
endmodule

// File: tb/tb_nand_cmd_addr_seq.sv
module tb_nand_cmd_addr_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] io_in = 8'h00;

  logic [7:0]  cmd_a, cmd_b;
  logic [39:0] addr_a, addr_b;
  logic [15:0] ofs_a, ofs_b;
  logic [7:0]  trg_a, trg_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // large page, 8-bit bus, 2048 Mbit
  nand_cmd_addr_seq dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle), .ale(ale),
    .io_in(io_in), .cmd_q(cmd_a), .addr_q(addr_a), .col_ofs(ofs_a),
    .t_rd_load(trg_a[7]), .t_rd_col(trg_a[6]), .t_prog_setup(trg_a[5]),
    .t_prog_go(trg_a[4]), .t_erase(trg_a[3]), .t_status(trg_a[2]),
    .t_id(trg_a[1]), .t_reset(trg_a[0])
  );

  // small page, 16-bit bus
  nand_cmd_addr_seq #(.LARGE_PAGE(1'b0), .BUS16(1'b1), .CAP_MBIT(128),
                      .SMALL_PAGE_BYTES(512)) dut_sp (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle), .ale(ale),
    .io_in(io_in), .cmd_q(cmd_b), .addr_q(addr_b), .col_ofs(ofs_b),
    .t_rd_load(trg_b[7]), .t_rd_col(trg_b[6]), .t_prog_setup(trg_b[5]),
    .t_prog_go(trg_b[4]), .t_erase(trg_b[3]), .t_status(trg_b[2]),
    .t_id(trg_b[1]), .t_reset(trg_b[0])
  );

  // trigger byte: 80 rd_load, 40 rd_col, 20 prog_setup, 10 prog_go,
  //               08 erase, 04 status, 02 id, 01 reset
  typedef struct packed {
    logic        ce_n;
    logic        cle;
    logic        ale;
    logic [7:0]  din;
    logic [7:0]  cmd;
    logic [39:0] addr;
    logic [15:0] ofs;
    logic [7:0]  trg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,8'h00,8'h00,40'h0,            16'h0000,8'h00,4'd3},  // R3
    '{1'b0,1'b0,1'b1,8'h11,8'h00,40'h11,           16'h0000,8'h00,4'd2},  // R2
    '{1'b0,1'b0,1'b1,8'h22,8'h00,40'h2211,         16'h0000,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h33,8'h00,40'h332211,       16'h0000,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h44,8'h00,40'h44332211,     16'h0000,8'h00,4'd7},  // R7
    '{1'b0,1'b0,1'b1,8'h55,8'h00,40'h5544332211,   16'h0000,8'h80,4'd7},
    '{1'b0,1'b1,1'b0,8'h30,8'h00,40'h5544332211,   16'h0000,8'h00,4'd4},  // R4
    '{1'b0,1'b1,1'b0,8'h05,8'h00,40'h5544330000,   16'h0000,8'h00,4'd4},
    '{1'b0,1'b0,1'b1,8'hAA,8'h00,40'h55443300AA,   16'h0000,8'h00,4'd4},
    '{1'b0,1'b0,1'b1,8'hBB,8'h00,40'h554433BBAA,   16'h0000,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,8'hE0,8'hE0,40'h554433BBAA,   16'h0000,8'h40,4'd5},  // R5
    '{1'b0,1'b0,1'b1,8'hCC,8'hE0,40'h5544CCBBAA,   16'h0000,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,8'h70,8'h70,40'h5544CCBBAA,   16'h0000,8'h04,4'd5},
    '{1'b0,1'b1,1'b0,8'h90,8'h90,40'h5544CCBBAA,   16'h0000,8'h00,4'd6},  // R6
    '{1'b0,1'b0,1'b1,8'h00,8'h90,40'h5544CCBB00,   16'h0000,8'h02,4'd6},
    '{1'b0,1'b1,1'b0,8'h60,8'h60,40'h5544CCBB00,   16'h0000,8'h00,4'd9},  // R9
    '{1'b0,1'b0,1'b1,8'h01,8'h60,40'h5544CCBB01,   16'h0000,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h02,8'h60,40'h5544CC0201,   16'h0000,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h03,8'h60,40'h5544030201,   16'h0000,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,8'hD0,8'hD0,40'h0302010000,   16'h0000,8'h08,4'd9},
    '{1'b0,1'b1,1'b0,8'h50,8'h00,40'h0302010000,   16'h0800,8'h00,4'd3},
    '{1'b0,1'b1,1'b0,8'h01,8'h00,40'h0302010000,   16'h0100,8'h00,4'd3},
    '{1'b0,1'b1,1'b0,8'h80,8'h80,40'h0302010000,   16'h0100,8'h00,4'd7},
    '{1'b0,1'b0,1'b1,8'h10,8'h80,40'h0302010010,   16'h0100,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h20,8'h80,40'h0302012010,   16'h0100,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h30,8'h80,40'h0302302010,   16'h0100,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,8'h40,8'h80,40'h0340302010,   16'h0100,8'h00,4'd7},
    '{1'b0,1'b0,1'b1,8'h50,8'h80,40'h5040302010,   16'h0100,8'h20,4'd7},
    '{1'b0,1'b1,1'b0,8'h10,8'h10,40'h5040302010,   16'h0100,8'h10,4'd5},
    '{1'b1,1'b1,1'b0,8'h70,8'h10,40'h5040302010,   16'h0100,8'h00,4'd1},  // R1
    '{1'b1,1'b0,1'b1,8'h99,8'h10,40'h5040302099,   16'h0100,8'h00,4'd1},
    '{1'b0,1'b1,1'b0,8'h42,8'h42,40'h5040302099,   16'h0100,8'h00,4'd11}, // R11
    '{1'b0,1'b1,1'b0,8'h35,8'h35,40'h5040302099,   16'h0100,8'h40,4'd5},
    '{1'b0,1'b1,1'b0,8'hFF,8'h00,40'h0,            16'h0000,8'h01,4'd10}, // R10
    '{1'b0,1'b0,1'b0,8'h77,8'h00,40'h0,            16'h0000,8'h00,4'd1}
  };

  task automatic chk(input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one strobe; returns at the following falling edge, outputs already registered
  task automatic put(input logic c_n, input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    ce_n = c_n; cle = c; ale = a; io_in = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk(12, "reset cmd", 64'(cmd_a), 64'h00);
    chk(12, "reset addr", 64'(addr_a), 64'h0);
    chk(12, "reset ofs", 64'(ofs_a), 64'h0);
    chk(12, "reset trig", 64'(trg_a), 64'h0);

    for (int i = 0; i < NV; i++) begin
      put(VECS[i].ce_n, VECS[i].cle, VECS[i].ale, VECS[i].din);
      chk(int'(VECS[i].req), $sformatf("vec%0d cmd", i),  64'(cmd_a),  64'(VECS[i].cmd));
      chk(int'(VECS[i].req), $sformatf("vec%0d addr", i), 64'(addr_a), 64'(VECS[i].addr));
      chk(int'(VECS[i].req), $sformatf("vec%0d ofs", i),  64'(ofs_a),  64'(VECS[i].ofs));
      chk(int'(VECS[i].req), $sformatf("vec%0d trig", i), 64'(trg_a),  64'(VECS[i].trg));
    end

    // R11: a pulse lasts one cycle
    put(1'b0, 1'b1, 1'b0, 8'h70);
    chk(11, "status pulse", 64'(trg_a), 64'h04);
    @(negedge clk);
    chk(11, "status pulse ends", 64'(trg_a), 64'h00);

    // small-page / 16-bit instance from a fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    put(1'b0, 1'b1, 1'b0, 8'h00);
    put(1'b0, 1'b0, 1'b1, 8'h12);
    chk(2, "sp first byte", 64'(addr_b), 64'h12);
    put(1'b0, 1'b0, 1'b1, 8'h34);
    chk(8, "sp bus16 shift", 64'(addr_b), 64'h6824);          // R8
    put(1'b0, 1'b0, 1'b1, 8'h56);
    chk(7, "sp third byte addr", 64'(addr_b), 64'h566824);     // R7
    chk(7, "sp read at cycle 3", 64'(trg_b), 64'h80);
    chk(7, "lp no read at cycle 3", 64'(trg_a), 64'h00);
    put(1'b0, 1'b1, 1'b0, 8'h50);
    chk(3, "sp spare offset", 64'(ofs_b), 64'h200);            // R3
    chk(3, "sp spare cmd", 64'(cmd_b), 64'h00);
    put(1'b0, 1'b1, 1'b0, 8'h30);
    chk(4, "sp 0x30 latches", 64'(cmd_b), 64'h30);             // R4
    chk(4, "lp 0x30 dropped", 64'(cmd_a), 64'h00);
    put(1'b0, 1'b1, 1'b0, 8'hE0);
    chk(5, "sp E0 cmd", 64'(cmd_b), 64'hE0);                   // R5
    chk(5, "sp E0 no pulse", 64'(trg_b), 64'h00);
    put(1'b0, 1'b1, 1'b0, 8'h60);
    put(1'b0, 1'b0, 1'b1, 8'h11);
    put(1'b0, 1'b0, 1'b1, 8'h22);
    chk(8, "sp shift on second byte", 64'(addr_b), 64'hAC4422);
    put(1'b0, 1'b1, 1'b0, 8'hD0);
    chk(9, "sp erase row", 64'(addr_b), 64'h442200);           // R9
    chk(9, "sp erase pulse", 64'(trg_b), 64'h08);

    // R1: command lines high without a strobe do nothing
    @(negedge clk);
    ce_n = 1'b0; cle = 1'b1; io_in = 8'hFF; wr_stb = 1'b0;
    @(negedge clk);
    chk(1, "no strobe cmd", 64'(cmd_b), 64'hD0);
    chk(1, "no strobe trig", 64'(trg_b), 64'h00);
    cle = 1'b0; ce_n = 1'b1;

    // R12: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(12, "mid reset cmd", 64'(cmd_b), 64'h00);
    chk(12, "mid reset addr", 64'(addr_b), 64'h0);
    chk(12, "mid reset ofs", 64'(ofs_b), 64'h0);
    chk(12, "mid reset trig", 64'(trg_b), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule